// File: doc/BRIEF.md
# Dual Down-Counting Timer with Reload

This peripheral holds two independent down-counters that step once per clock. Each one has a run bit and an auto-reload bit, and both pairs live in one shared control word. Each counter also has a reload register and a live count register. Software reaches all of these registers over a plain single-cycle register bus.

A counter can be programmed in two ways. In one-shot mode, software writes a delay straight into the live count and sets the run bit with auto-reload cleared. In periodic mode, auto-reload is set and the counter refills from its reload register after each expiry, so a reload value of N-1 gives an event every N clocks. A counter loaded with all ones and left in periodic mode serves as a free-running time base: the elapsed clocks equal all-ones minus the value read back.

Each expiry latches a flag in a small cause register. A mask register decides which flags drive the single interrupt line. Software clears a flag by writing a zero to its bit.

Top module: `tick_timer_pair`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero: control, cause, mask, both reload registers and both count registers. The interrupt output is low.
- R2: The control word sits at offset 0x00. Bit 0 runs counter 0, bit 1 enables reload for counter 0, bit 2 runs counter 1 and bit 3 enables reload for counter 1. Higher written bits read back as zero.
- R3: A running counter that is nonzero and is not being written decreases by exactly one on each clock. A counter whose run bit is clear keeps its value.
- R4: A write to a count register loads that value on the next clock edge. This write takes precedence over counting, so a running counter can be re-armed. Reload registers sit at 0x10 and 0x18 and count registers at 0x14 and 0x1C, for counter 0 and counter 1.
- R5: With reload disabled, a counter written with D and then started reaches zero D clocks after the start edge. It sets its cause flag on that same edge, stays at zero with its run bit still set, and does not set the flag again until it is loaded with a new value.
- R6: With reload enabled, a counter at zero refills from its reload register on the next clock, so a reload of P-1 gives a count period of P. The cause flag sets when the count steps from 1 to 0. When the reload value is zero, it also sets on every clock that the counter sits at zero.
- R7: The cause register is at 0x04, with bit 0 for counter 0 and bit 1 for counter 1. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R8: If an expiry and a clearing write to the same cause bit happen in the same cycle, the bit ends up set.
- R9: The mask register is at 0x08, with bit 0 for counter 0 and bit 1 for counter 1, where 1 lets the flag through. The interrupt output is high exactly when some cause bit and its mask bit are both set. A masked flag stays latched in the cause register but does not raise the line.
- R10: Reads are combinational and return the live count. Offsets that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every counter steps on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | Access is a write when high |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt, high while an unmasked cause flag is set |

## Verification
The hardest case to reach from the ports is an expiry and a cause-clearing write landing on the same clock edge. The bench counts clocks from the edge that starts a three-tick one-shot, so that its clearing write lands on the edge where the count steps from 1 to 0. It then checks that the flag is still set. The bench also sweeps one-shot delays from 1 to 10 and reload periods from 1 to 8. It compares the live count on every cycle against the arithmetic expected value, including the reload-of-zero case where the flag must fire continuously. Finally it checks all four mask combinations against a latched pair of flags.

// File: rtl/tmr_pkg.sv
// Shared constants for the dual timer: register offsets, bus width and
// the number of counters. The map places counter i's reload register at
// 0x10 + 8*i and its count register at 0x14 + 8*i.
package tmr_pkg;
    localparam int unsigned NUM_TMR = 2;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h08;

    // Offset of the reload register for counter idx.
    function automatic logic [ADDR_W-1:0] rld_ofs(input int idx);
        return ADDR_W'(16 + 8 * idx);
    endfunction

    // Offset of the live count register for counter idx.
    function automatic logic [ADDR_W-1:0] val_ofs(input int idx);
        return ADDR_W'(20 + 8 * idx);
    endfunction
endpackage

// File: rtl/tmr_decode.sv
// Address decoder and read multiplexer.
// Assumes single-cycle accesses: a write strobe is valid only while
// sel and wr are both high. Reads ignore sel and are purely combinational.
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                        sel_i,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [2*NUM_TMR-1:0]        ctrl_i,
    input  logic [NUM_TMR-1:0]          cause_i,
    input  logic [NUM_TMR-1:0]          mask_i,
    input  logic [NUM_TMR-1:0][CNT_W-1:0] rld_i,
    input  logic [NUM_TMR-1:0][CNT_W-1:0] val_i,
    output logic                        wr_ctrl_o,
    output logic                        wr_cause_o,
    output logic                        wr_mask_o,
    output logic [NUM_TMR-1:0]          wr_rld_o,
    output logic [NUM_TMR-1:0]          wr_val_o,
    output logic [DATA_W-1:0]           rdata_o
);
    logic wr_en;
    assign wr_en = sel_i && wr_i;

    // Write strobes for the shared registers.
    assign wr_ctrl_o  = wr_en && (addr_i == OFS_CTRL);
    assign wr_cause_o = wr_en && (addr_i == OFS_CAUSE);
    assign wr_mask_o  = wr_en && (addr_i == OFS_MASK);

    // Write strobes for the per-counter registers.
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_strobe
        assign wr_rld_o[i] = wr_en && (addr_i == rld_ofs(i));
        assign wr_val_o[i] = wr_en && (addr_i == val_ofs(i));
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_CTRL)  rdata_o = DATA_W'(ctrl_i);
        if (addr_i == OFS_CAUSE) rdata_o = DATA_W'(cause_i);
        if (addr_i == OFS_MASK)  rdata_o = DATA_W'(mask_i);
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr_i == rld_ofs(i)) rdata_o = DATA_W'(rld_i[i]);
            if (addr_i == val_ofs(i)) rdata_o = DATA_W'(val_i[i]);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// One down-counter with its reload register.
// Behaviour: a load write wins over counting. A running nonzero counter
// decrements. A running counter at zero refills from reload when
// auto-reload is on, and otherwise parks at zero. expire_o pulses on the
// cycle the count steps 1->0, and also on a zero-to-zero refill when the
// reload value is zero.
module tmr_channel #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rld_en_i,
    input  logic             wr_rld_i,
    input  logic             wr_val_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rld_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire_o
);
    logic at_zero;
    logic at_one;
    assign at_zero = (cnt_q == '0);
    assign at_one  = (cnt_q == CNT_W'(1));

    // Reload register: written from the bus only.
    always_ff @(posedge clk) begin
        if (!rst_n)        rld_q <= '0;
        else if (wr_rld_i) rld_q <= wdata_i;
    end

    // Live counter: load, decrement, refill or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (wr_val_i)            cnt_q <= wdata_i;
        else if (en_i && !at_zero)    cnt_q <= cnt_q - CNT_W'(1);
        else if (en_i && rld_en_i)    cnt_q <= rld_q;
    end

    // Expiry pulse: the count enters zero this cycle.
    assign expire_o = en_i && !wr_val_i &&
                      (at_one || (at_zero && rld_en_i && rld_q == '0));

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !wr_val_i && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_val_i) |=> $stable(cnt_q)); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val_i |=> (cnt_q == $past(wdata_i))); // R4
    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !rld_en_i && !wr_val_i && at_zero) |=> (cnt_q == '0)); // R5
    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld_en_i && at_zero) |-> !expire_o); // R5
    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rld_en_i && !wr_val_i && !wr_rld_i && at_zero) |=> (cnt_q == $past(rld_q))); // R6
endmodule

// File: rtl/tmr_cause.sv
// Cause and mask registers with the interrupt combine.
// Cause bits are write-zero-to-clear, and a same-cycle expiry wins over
// a clear. Mask bits are plain read/write, where 1 passes the flag.
module tmr_cause
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire_i,
    input  logic               wr_cause_i,
    input  logic               wr_mask_i,
    input  logic [NUM_TMR-1:0] wdata_i,
    output logic [NUM_TMR-1:0] cause_q,
    output logic [NUM_TMR-1:0] mask_q,
    output logic               irq_o
);
    // Mask register: written from the bus only.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (wr_mask_i) mask_q <= wdata_i;
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_bit
        // Cause flag: set on expiry, cleared by a written zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                         cause_q[i] <= 1'b0;
            else if (expire_i[i])               cause_q[i] <= 1'b1;
            else if (wr_cause_i && !wdata_i[i]) cause_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            expire_i[i] |=> cause_q[i]); // R8
        AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cause_i && !wdata_i[i] && !expire_i[i]) |=> !cause_q[i]); // R7
        AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (!expire_i[i] && !(wr_cause_i && !wdata_i[i])) |=> $stable(cause_q[i])); // R7
    end

    // Interrupt line: any flag that its mask lets through.
    assign irq_o = |(cause_q & mask_q);
endmodule

// File: rtl/tick_timer_pair.sv
// Top of the dual down-counting timer.
// Holds the shared control word and instantiates the decoder, one
// channel per counter and the cause/mask block.
// Assumes CNT_W <= 32. Control bit 2*i runs counter i, and bit 2*i+1
// enables its auto-reload.
module tick_timer_pair
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int unsigned CTRL_W = 2 * NUM_TMR;

    logic [CTRL_W-1:0]              ctrl_q;
    logic                           wr_ctrl, wr_cause, wr_mask;
    logic [NUM_TMR-1:0]             wr_rld, wr_val, expire;
    logic [NUM_TMR-1:0]             cause_q, mask_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]  rld_q, cnt_q;

    // Control word: per-counter run and auto-reload bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    tmr_decode #(.CNT_W(CNT_W)) u_decode (
        .sel_i      (bus_sel),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .ctrl_i     (ctrl_q),
        .cause_i    (cause_q),
        .mask_i     (mask_q),
        .rld_i      (rld_q),
        .val_i      (cnt_q),
        .wr_ctrl_o  (wr_ctrl),
        .wr_cause_o (wr_cause),
        .wr_mask_o  (wr_mask),
        .wr_rld_o   (wr_rld),
        .wr_val_o   (wr_val),
        .rdata_o    (bus_rdata)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
        tmr_channel #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ctrl_q[2*i]),
            .rld_en_i (ctrl_q[2*i+1]),
            .wr_rld_i (wr_rld[i]),
            .wr_val_i (wr_val[i]),
            .wdata_i  (bus_wdata[CNT_W-1:0]),
            .rld_q    (rld_q[i]),
            .cnt_q    (cnt_q[i]),
            .expire_o (expire[i])
        );
    end

    tmr_cause u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .wr_cause_i (wr_cause),
        .wr_mask_i  (wr_mask),
        .wdata_i    (bus_wdata[NUM_TMR-1:0]),
        .cause_q    (cause_q),
        .mask_q     (mask_q),
        .irq_o      (irq_o)
    );

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q)); // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && cause_q == '0 && !irq_o)); // R1
endmodule

// File: tb/test_tick_timer_pair.sv
module test_tick_timer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;  // 50 MHz

    tick_timer_pair i_tick_timer_pair (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    localparam logic [4:0] A_CTRL = 5'h00, A_CAUSE = 5'h04, A_MASK = 5'h08;
    localparam logic [4:0] A_RLD0 = 5'h10, A_VAL0 = 5'h14;
    localparam logic [4:0] A_RLD1 = 5'h18, A_VAL1 = 5'h1C;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset values
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_CAUSE, v); check("R1 cause", v, 0);
        rd(A_MASK, v);  check("R1 mask", v, 0);
        rd(A_RLD0, v);  check("R1 rld0", v, 0);
        rd(A_VAL0, v);  check("R1 val0", v, 0);
        rd(A_RLD1, v);  check("R1 rld1", v, 0);
        rd(A_VAL1, v);  check("R1 val1", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);

        // R2: control bits read back, upper bits dropped
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 32'hF);
        wr(A_CTRL, 32'h5);
        rd(A_CTRL, v); check("R2 ctrl pattern", v, 32'h5);
        wr(A_CTRL, 0);
        rd(A_CTRL, v); check("R2 ctrl off", v, 0);

        // R10: unmapped offset reads zero
        rd(5'h0C, v); check("R10 unmapped", v, 0);

        // R3 R10: counter 0 free-running from all ones
        wr(A_VAL0, 32'hFFFF_FFFF);
        wr(A_RLD0, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h3);
        for (int k = 0; k <= 20; k++) begin
            rd(A_VAL0, v);
            check("R3 elapsed ticks", 32'hFFFF_FFFF - v, k);
            tick(1);
        end
        wr(A_CTRL, 0);
        rd(A_VAL0, held);
        tick(5);
        rd(A_VAL0, v); check("R3 hold when stopped", v, held);

        // R6 R7: counter 0 periodic wrap from 2 with reload 4
        wr(A_CAUSE, 0);
        wr(A_VAL0, 2);
        wr(A_RLD0, 4);
        wr(A_CTRL, 32'h3);
        for (int k = 0; k <= 12; k++) begin
            rd(A_VAL0, v);
            check("R6 ctr0 wrap", v, (k <= 2) ? 32'(2 - k) : 32'(4 - ((k - 3) % 5)));
            rd(A_CAUSE, v);
            check("R6 ctr0 flag", v & 1, (k >= 2) ? 1 : 0);
            tick(1);
        end
        wr(A_CTRL, 0);
        wr(A_CAUSE, 32'hFFFF_FFFE);
        rd(A_CAUSE, v); check("R7 clear bit0", v, 0);

        // R5: one-shot sweep on counter 1
        for (int d = 1; d <= 10; d++) begin
            wr(A_CTRL, 0);
            wr(A_CAUSE, 0);
            wr(A_VAL1, d);
            wr(A_CTRL, 32'h4);
            for (int k = 0; k <= d; k++) begin
                rd(A_VAL1, v);  check("R5 oneshot count", v, 32'(d - k));
                rd(A_CAUSE, v); check("R5 oneshot flag", v, (k == d) ? 2 : 0);
                tick(1);
            end
            tick(3);
            rd(A_VAL1, v);  check("R5 parked at zero", v, 0);
            rd(A_CTRL, v);  check("R5 run bit kept", v, 32'h4);
            wr(A_CAUSE, 32'hFFFF_FFFD);
            rd(A_CAUSE, v); check("R7 clear bit1", v, 0);
            tick(5);
            rd(A_CAUSE, v); check("R5 no second flag", v, 0);
        end

        // R6: periodic sweep on counter 1, period P = reload + 1
        for (int p = 1; p <= 8; p++) begin
            wr(A_CTRL, 0);
            wr(A_CAUSE, 0);
            wr(A_RLD1, p - 1);
            wr(A_VAL1, p - 1);
            wr(A_CTRL, 32'hC);
            for (int k = 0; k <= 3 * p; k++) begin
                rd(A_VAL1, v);
                check("R6 period count", v, 32'((p - 1 - (k % p) + p) % p));
                rd(A_CAUSE, v);
                check("R6 period flag", v, (k >= ((p > 1) ? p - 1 : 1)) ? 2 : 0);
                tick(1);
            end
        end

        // R8: expiry and clear on the same edge
        wr(A_CTRL, 0);
        wr(A_CAUSE, 0);
        wr(A_VAL1, 3);
        wr(A_CTRL, 32'h4);
        tick(2);
        wr(A_CAUSE, 0);
        rd(A_CAUSE, v); check("R8 set beats clear", v, 2);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); check("R7 ones keep flag", v, 2);

        // R4: re-arm a running counter
        wr(A_CTRL, 0);
        wr(A_CAUSE, 0);
        wr(A_VAL1, 100);
        wr(A_CTRL, 32'h4);
        tick(5);
        rd(A_VAL1, v); check("R4 running", v, 95);
        wr(A_VAL1, 4);
        for (int k = 0; k <= 4; k++) begin
            rd(A_VAL1, v);  check("R4 rearm count", v, 32'(4 - k));
            rd(A_CAUSE, v); check("R4 rearm flag", v, (k == 4) ? 2 : 0);
            tick(1);
        end

        // R9: mask sweep over both flags latched
        wr(A_CTRL, 0);
        wr(A_CAUSE, 0);
        wr(A_VAL0, 1);
        wr(A_VAL1, 1);
        wr(A_CTRL, 32'h5);
        tick(1);
        rd(A_CAUSE, v); check("R9 both flags", v, 3);
        for (int m = 0; m < 4; m++) begin
            wr(A_MASK, m);
            rd(A_MASK, v);  check("R9 mask readback", v, m);
            check("R9 irq", {31'b0, irq_o}, (m != 0) ? 1 : 0);
            rd(A_CAUSE, v); check("R9 flags latched", v, 3);
        end
        wr(A_MASK, 3);
        wr(A_CAUSE, 32'hFFFF_FFFE);
        check("R9 irq one left", {31'b0, irq_o}, 1);
        wr(A_MASK, 1);
        check("R9 masked flag no irq", {31'b0, irq_o}, 0);
        rd(A_CAUSE, v); check("R9 masked still latched", v, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule